// File: doc/BRIEF.md
# Dual FIFO Sticky Status Tracker

This block holds two FIFOs of the same depth and width. One carries outbound data: software writes it and a serial engine drains it. The other carries inbound data: the serial engine fills it and software drains it. The block watches the occupancy of both FIFOs and keeps an 8-bit status word.

Six bits of the status word are event flags. Each one records that a FIFO became empty, became full, or crossed its programmed threshold at some point since software last read the status word. A status-read strobe clears these six bits.

The other two bits record software misuse: a write into a full outbound FIFO, or a read from an empty inbound FIFO. A status read does not clear these two bits. Only the software reset strobe clears them, and that strobe also empties both FIFOs.

Both FIFOs present their oldest entry on the read data port in the same cycle (show-ahead). A read pops that entry at the next clock edge. The occupancy counts are outputs, and every status bit is updated at the same clock edge as the counts that caused it.

Top module: `dfs_sticky_status`

## Requirements
- R1: After `rst_n` is held low across a clock edge, `stat_word` is 0x00, both counts are 0 and both read data ports show 0.
- R2: Each FIFO returns its entries in the order they were written. The read data port shows the oldest entry while the count is non-zero. A count moves by +1 for an accepted write and by −1 for an accepted read, and stays between 0 and DEPTH.
- R3: A `tx_wr_en` while `tx_count` equals DEPTH is discarded, even if a TX read happens in the same cycle. It sets bit 6 (TX overflow error) at that edge.
- R4: An `rx_rd_en` while `rx_count` is 0 does not move the FIFO. `rx_rd_data` shows 0 while the FIFO is empty. Such a read sets bit 7 (RX underflow error).
- R5: Bits 7 and 6 stay set through any number of status reads. A cycle with `sw_rst` high clears the whole status word and empties both FIFOs at that edge. `sw_rst` overrides every other input in that cycle.
- R6: Bit 0 (TX empty) sets when `tx_count` goes from non-zero to 0. Bit 3 (RX empty) sets when `rx_count` goes from non-zero to 0.
- R7: Bit 1 (TX full) sets when `tx_count` goes from below DEPTH to DEPTH. Bit 4 (RX full) does the same for `rx_count`.
- R8: Bit 5 (RX threshold) sets when `rx_count` moves from below `rx_thresh` to at or above it. With `rx_thresh` at 0 the bit never sets.
- R9: Bit 2 (TX threshold) sets when `tx_count` moves from above `tx_thresh` to at or below it.
- R10: A cycle with `stat_rd` high clears bits 5..0 at that edge. If an event for a bit occurs in the same cycle, that bit is 1 afterwards.
- R11: Event bits set only when a condition is entered. A FIFO that stays empty or full does not set its bit again after a status read.
- R12: A TX read while `tx_count` is 0 and an RX write while `rx_count` is DEPTH have no effect on data, counts or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_rst | input | 1 | Software reset strobe: flushes both FIFOs, clears status |
| tx_wr_en | input | 1 | Software write into the TX FIFO |
| tx_wr_data | input | WIDTH | TX write data |
| tx_rd_en | input | 1 | Engine pop from the TX FIFO |
| tx_rd_data | output | WIDTH | Oldest TX entry, 0 when empty |
| rx_wr_en | input | 1 | Engine write into the RX FIFO |
| rx_wr_data | input | WIDTH | RX write data |
| rx_rd_en | input | 1 | Software pop from the RX FIFO |
| rx_rd_data | output | WIDTH | Oldest RX entry, 0 when empty |
| tx_thresh | input | CW | TX threshold level |
| rx_thresh | input | CW | RX threshold level |
| stat_rd | input | 1 | Status-read strobe |
| stat_word | output | 8 | Status flags |
| tx_count | output | CW | TX occupancy, 0..DEPTH |
| rx_count | output | CW | RX occupancy, 0..DEPTH |

## Verification
The bench targets several corner cases:
- A full-FIFO write that coincides with a pop. A design that judged the write against the count after the pop would accept it and miss the overflow error.
- A status read in the same cycle as a flag-setting event. Giving the clear priority would silently drop that event.
- A FIFO that is held empty or full across a status read. A level-sensitive design would re-raise the bit.
- A status read while an error bit is set. A design that cleared the error bits on read would lose the error.
- An RX threshold of 0 and thresholds reprogrammed at random points. Comparing against the old count instead of the updated one would fire the threshold bits a cycle late or at the wrong level.

// File: rtl/dfs_pkg.sv
// Package dfs_pkg
// Shared bit positions and event type for the dual FIFO status tracker.
// Assumes an 8-bit status word whose positions are fixed for the bus side.
package dfs_pkg;
    localparam int STAT_W     = 8;
    localparam int B_TX_EMPTY = 0;
    localparam int B_TX_FULL  = 1;
    localparam int B_TX_THR   = 2;
    localparam int B_RX_EMPTY = 3;
    localparam int B_RX_FULL  = 4;
    localparam int B_RX_THR   = 5;
    localparam int B_TX_OVF   = 6;
    localparam int B_RX_UNF   = 7;
    // Error bits survive a status read; all others clear on read.
    localparam logic [STAT_W-1:0] ERR_MASK = 8'hC0;

    typedef struct packed {
        logic to_empty;
        logic to_full;
        logic to_thr;
    } occ_evt_t;
endpackage

// File: rtl/dfs_fifo.sv
// Module dfs_fifo
// Circular-buffer FIFO with show-ahead read data and an occupancy count.
// Writes into a full FIFO and reads from an empty one are ignored; the
// read port shows zero while empty. count_next gives the occupancy that
// will be loaded at the coming edge. flush empties the FIFO synchronously.
// Assumes DEPTH >= 2.
module dfs_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic [CW-1:0]    count_next
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             wr_ok, rd_ok;

    // Wrap a pointer at the last slot (depth need not be a power of two).
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Accept decisions use the occupancy before this cycle's update.
    always_comb begin
        wr_ok      = wr_en && (count != FULL_CNT);
        rd_ok      = rd_en && (count != '0);
        count_next = flush ? '0 : count + CW'(wr_ok) - CW'(rd_ok);
    end

    // Pointer and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= bump(wptr);
            if (rd_ok) rptr <= bump(rptr);
            count <= count_next;
        end
    end

    // Storage array, written on accepted writes only.
    always_ff @(posedge clk) begin
        if (wr_ok && !flush) mem[wptr] <= wr_data;
    end

    // Show-ahead head entry, zero while empty.
    assign rd_data = (count != '0) ? mem[rptr] : '0;
endmodule

// File: rtl/dfs_occ_events.sv
// Module dfs_occ_events
// Detects entry into empty, full and threshold conditions by comparing the
// current occupancy with the occupancy loaded at the next edge.
// FALLING_THR = 1 fires when the count falls to or below the threshold;
// FALLING_THR = 0 fires when it rises to or above it. No events on flush.
module dfs_occ_events
    import dfs_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int CW          = $clog2(DEPTH + 1),
    parameter bit FALLING_THR = 1'b0
) (
    input  logic          flush,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] count_next,
    input  logic [CW-1:0] thresh,
    output occ_evt_t      evt
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    logic thr_cross;

    // Threshold direction chosen at elaboration.
    generate
        if (FALLING_THR) begin : g_fall
            assign thr_cross = (count_next <= thresh) && (count > thresh);
        end else begin : g_rise
            assign thr_cross = (count_next >= thresh) && (count < thresh);
        end
    endgenerate

    // Entry events, suppressed by a flush.
    always_comb begin
        evt.to_empty = !flush && (count_next == '0) && (count != '0);
        evt.to_full  = !flush && (count_next == FULL_CNT) && (count != FULL_CNT);
        evt.to_thr   = !flush && thr_cross;
    end
endmodule

// File: rtl/dfs_status_regs.sv
// Module dfs_status_regs
// Per-bit sticky flags. Bits named in ERR_MASK hold until a software reset;
// the rest clear on a status read. A set in the same cycle as a read wins.
module dfs_status_regs
    import dfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              stat_rd,
    input  logic [STAT_W-1:0] set_vec,
    output logic [STAT_W-1:0] stat
);
    generate
        for (genvar b = 0; b < STAT_W; b++) begin : g_bit
            if (ERR_MASK[b]) begin : g_err
                // Error bit: sticky until a software reset.
                always_ff @(posedge clk) begin
                    if (!rst_n || sw_rst) stat[b] <= 1'b0;
                    else                  stat[b] <= stat[b] | set_vec[b];
                end
            end else begin : g_evt
                // Event bit: cleared by a status read unless set again.
                always_ff @(posedge clk) begin
                    if (!rst_n || sw_rst) stat[b] <= 1'b0;
                    else                  stat[b] <= set_vec[b] | (stat[b] & ~stat_rd);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dfs_sticky_status.sv
// Module dfs_sticky_status (top)
// Outbound (TX) and inbound (RX) FIFOs plus an 8-bit sticky status word.
// Software writes TX and reads RX; the serial engine does the opposite.
// Misuse by software raises error bits 6/7; engine-side misuse is ignored.
// Assumes all inputs are synchronous to clk.
module dfs_sticky_status
    import dfs_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             tx_wr_en,
    input  logic [WIDTH-1:0] tx_wr_data,
    input  logic             tx_rd_en,
    output logic [WIDTH-1:0] tx_rd_data,
    input  logic             rx_wr_en,
    input  logic [WIDTH-1:0] rx_wr_data,
    input  logic             rx_rd_en,
    output logic [WIDTH-1:0] rx_rd_data,
    input  logic [CW-1:0]    tx_thresh,
    input  logic [CW-1:0]    rx_thresh,
    input  logic             stat_rd,
    output logic [7:0]       stat_word,
    output logic [CW-1:0]    tx_count,
    output logic [CW-1:0]    rx_count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0]     tx_cnt_nx, rx_cnt_nx;
    occ_evt_t          tx_evt, rx_evt;
    logic [STAT_W-1:0] set_vec;

    dfs_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(sw_rst),
        .wr_en(tx_wr_en), .wr_data(tx_wr_data),
        .rd_en(tx_rd_en), .rd_data(tx_rd_data),
        .count(tx_count), .count_next(tx_cnt_nx)
    );

    dfs_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(sw_rst),
        .wr_en(rx_wr_en), .wr_data(rx_wr_data),
        .rd_en(rx_rd_en), .rd_data(rx_rd_data),
        .count(rx_count), .count_next(rx_cnt_nx)
    );

    dfs_occ_events #(.DEPTH(DEPTH), .CW(CW), .FALLING_THR(1'b1)) u_tx_evt (
        .flush(sw_rst), .count(tx_count), .count_next(tx_cnt_nx),
        .thresh(tx_thresh), .evt(tx_evt)
    );

    dfs_occ_events #(.DEPTH(DEPTH), .CW(CW), .FALLING_THR(1'b0)) u_rx_evt (
        .flush(sw_rst), .count(rx_count), .count_next(rx_cnt_nx),
        .thresh(rx_thresh), .evt(rx_evt)
    );

    // Gather this cycle's set requests into status bit positions.
    always_comb begin
        set_vec             = '0;
        set_vec[B_TX_EMPTY] = tx_evt.to_empty;
        set_vec[B_TX_FULL]  = tx_evt.to_full;
        set_vec[B_TX_THR]   = tx_evt.to_thr;
        set_vec[B_RX_EMPTY] = rx_evt.to_empty;
        set_vec[B_RX_FULL]  = rx_evt.to_full;
        set_vec[B_RX_THR]   = rx_evt.to_thr;
        set_vec[B_TX_OVF]   = !sw_rst && tx_wr_en && (tx_count == FULL_CNT);
        set_vec[B_RX_UNF]   = !sw_rst && rx_rd_en && (rx_count == '0);
    end

    dfs_status_regs u_stat (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .stat_rd(stat_rd),
        .set_vec(set_vec), .stat(stat_word)
    );
endmodule

// File: rtl/dfs_checker.sv
// Module dfs_checker
// Port-level properties of dfs_sticky_status, attached by bind below.
module dfs_checker #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_rst,
    input logic             tx_wr_en,
    input logic             rx_rd_en,
    input logic             stat_rd,
    input logic [WIDTH-1:0] rx_rd_data,
    input logic [7:0]       stat_word,
    input logic [CW-1:0]    tx_count,
    input logic [CW-1:0]    rx_count
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= FULL_CNT) && (rx_count <= FULL_CNT));

    a_r3_tx_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr_en && tx_count == FULL_CNT && !sw_rst) |=> stat_word[6]);

    a_r3_overflow_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == FULL_CNT && !sw_rst) |=> (tx_count >= FULL_CNT - 1'b1));

    a_r4_rx_underflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_en && rx_count == '0 && !sw_rst) |=> stat_word[7]);

    a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> (rx_rd_data == '0));

    a_r5_err_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[7:6] != 2'b00 && !sw_rst) |=> (stat_word[7:6] >= $past(stat_word[7:6])));

    a_r5_swrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (stat_word == 8'h00 && tx_count == '0 && rx_count == '0));

    a_r6_tx_empty_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count != '0 && !sw_rst) |=> (tx_count != '0 || stat_word[0]));

    a_r7_rx_full_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count != FULL_CNT && !sw_rst) |=> (rx_count != FULL_CNT || stat_word[4]));

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !sw_rst && tx_count == '0 && !$rose(stat_word[0])) |=> !stat_word[0]);
endmodule

bind dfs_sticky_status dfs_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .tx_wr_en(tx_wr_en),
    .rx_rd_en(rx_rd_en), .stat_rd(stat_rd), .rx_rd_data(rx_rd_data),
    .stat_word(stat_word), .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/dfs_sticky_status_tb_top.sv
// Bench for dfs_sticky_status: behavioural queue model compared every cycle,
// plus directed checks of the corner cases.
module dfs_sticky_status_tb_top;
    localparam int W     = 8;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n, sw_rst, tx_wr_en, tx_rd_en, rx_wr_en, rx_rd_en, stat_rd;
    logic [W-1:0]  tx_wr_data, rx_wr_data, tx_rd_data, rx_rd_data;
    logic [CW-1:0] tx_thresh, rx_thresh, tx_count, rx_count;
    logic [7:0]    stat_word;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] q_tx[$];
    logic [W-1:0] q_rx[$];
    logic [7:0]   m_stat;

    always #4 clk = ~clk;

    dfs_sticky_status #(.WIDTH(W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data),
        .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .stat_rd(stat_rd), .stat_word(stat_word),
        .tx_count(tx_count), .rx_count(rx_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string bit_req(input int b);
        case (b)
            0, 3:    return "R6";
            1, 4:    return "R7";
            2:       return "R9";
            5:       return "R8";
            6:       return "R3";
            default: return "R4";
        endcase
    endfunction

    // Compare every output with the model (called between edges).
    task automatic compare_all();
        for (int b = 0; b < 8; b++) chk(bit_req(b), 32'(stat_word[b]), 32'(m_stat[b]));
        chk("R2 tx_count", 32'(tx_count), 32'(q_tx.size()));
        chk("R2 rx_count", 32'(rx_count), 32'(q_rx.size()));
        chk("R2 tx_rd_data", 32'(tx_rd_data), 32'(q_tx.size() != 0 ? q_tx[0] : 8'h00));
        chk("R4 rx_rd_data", 32'(rx_rd_data), 32'(q_rx.size() != 0 ? q_rx[0] : 8'h00));
    endtask

    // One clock: drive inputs, advance the model, wait an edge, compare.
    task automatic cyc(input bit twe, input logic [W-1:0] twd, input bit tre,
                       input bit rwe, input logic [W-1:0] rwd, input bit rre,
                       input bit srd, input bit swr);
        int tc, rc, tn, rn, tth, rth;
        logic [7:0] s;
        tx_wr_en = twe; tx_wr_data = twd; tx_rd_en = tre;
        rx_wr_en = rwe; rx_wr_data = rwd; rx_rd_en = rre;
        stat_rd = srd; sw_rst = swr;
        tth = int'(tx_thresh); rth = int'(rx_thresh);
        if (swr) begin
            q_tx.delete(); q_rx.delete(); m_stat = 8'h00;
        end else begin
            s = 8'h00;
            tc = q_tx.size(); rc = q_rx.size();
            if (tre && tc > 0) void'(q_tx.pop_front());
            if (twe) begin
                if (tc < DEPTH) q_tx.push_back(twd);
                else s[6] = 1'b1;
            end
            if (rre) begin
                if (rc > 0) void'(q_rx.pop_front());
                else s[7] = 1'b1;
            end
            if (rwe && rc < DEPTH) q_rx.push_back(rwd);
            tn = q_tx.size(); rn = q_rx.size();
            s[0] = (tn == 0) && (tc != 0);
            s[1] = (tn == DEPTH) && (tc != DEPTH);
            s[2] = (tn <= tth) && (tc > tth);
            s[3] = (rn == 0) && (rc != 0);
            s[4] = (rn == DEPTH) && (rc != DEPTH);
            s[5] = (rn >= rth) && (rc < rth);
            m_stat = s | (srd ? (m_stat & 8'hC0) : m_stat);
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input bit srd);
        cyc(0, 8'h00, 0, 0, 8'h00, 0, srd, 0);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sw_rst = 1'b0; stat_rd = 1'b0;
        tx_wr_en = 1'b0; tx_rd_en = 1'b0; rx_wr_en = 1'b0; rx_rd_en = 1'b0;
        tx_wr_data = '0; rx_wr_data = '0;
        tx_thresh = CW'(1); rx_thresh = CW'(3);
        m_stat = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk("R1 stat_word", 32'(stat_word), 32'h0);
        chk("R1 tx_count", 32'(tx_count), 32'h0);
        chk("R1 rx_count", 32'(rx_count), 32'h0);
        chk("R1 rd_data", 32'({tx_rd_data, rx_rd_data}), 32'h0);

        // R7/R2: fill TX to full.
        for (int i = 0; i < DEPTH; i++) cyc(1, 8'hA0 + 8'(i), 0, 0, 8'h00, 0, 0, 0);
        chk("R7 tx full bit", 32'(stat_word[1]), 32'h1);
        // R3: full write with a same-cycle pop is still rejected.
        cyc(1, 8'hEE, 1, 0, 8'h00, 0, 0, 0);
        chk("R3 overflow bit", 32'(stat_word[6]), 32'h1);
        chk("R3 count after pop", 32'(tx_count), 32'(DEPTH - 1));
        // R10/R5: status read clears events, keeps error.
        idle(1);
        chk("R10 events cleared", 32'(stat_word[5:0]), 32'h0);
        chk("R5 error kept", 32'(stat_word[6]), 32'h1);
        // R9: drain to threshold 1.
        for (int i = 0; i < DEPTH - 2; i++) cyc(0, 8'h00, 1, 0, 8'h00, 0, 0, 0);
        chk("R9 tx threshold bit", 32'(stat_word[2]), 32'h1);
        // R10: last pop with status read in the same cycle, set wins.
        cyc(0, 8'h00, 1, 0, 8'h00, 0, 1, 0);
        chk("R10 set beats clear", 32'(stat_word[0]), 32'h1);
        chk("R10 threshold cleared", 32'(stat_word[2]), 32'h0);
        // R11: held empty, bit does not return after a read.
        idle(1);
        idle(0);
        chk("R11 no re-set while empty", 32'(stat_word[0]), 32'h0);
        // R12: TX pop while empty has no effect.
        cyc(0, 8'h00, 1, 0, 8'h00, 0, 0, 0);
        chk("R12 empty pop status", 32'(stat_word), 32'h40);
        chk("R12 empty pop count", 32'(tx_count), 32'h0);
        // R4: RX read while empty.
        cyc(0, 8'h00, 0, 0, 8'h00, 1, 0, 0);
        chk("R4 underflow bit", 32'(stat_word[7]), 32'h1);
        chk("R4 data zero", 32'(rx_rd_data), 32'h0);
        // R8 then R7 then R12 on the RX side.
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 1, 8'h50 + 8'(i), 0, 0, 0);
        chk("R8 rx threshold bit", 32'(stat_word[5]), 32'h1);
        cyc(0, 8'h00, 0, 1, 8'h53, 0, 1, 0);
        chk("R7 rx full bit", 32'(stat_word[4]), 32'h1);
        cyc(0, 8'h00, 0, 1, 8'h77, 0, 0, 0);
        chk("R12 full rx write count", 32'(rx_count), 32'(DEPTH));
        chk("R12 full rx write head", 32'(rx_rd_data), 32'h50);
        // R5: software reset clears everything.
        cyc(1, 8'h11, 0, 1, 8'h22, 1, 1, 1);
        chk("R5 swrst status", 32'(stat_word), 32'h0);
        chk("R5 swrst counts", 32'({tx_count, rx_count}), 32'h0);
        // R8: threshold 0 never fires.
        rx_thresh = '0;
        cyc(0, 8'h00, 0, 1, 8'h33, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 8'h00, 1, 0, 0);
        chk("R8 zero threshold", 32'(stat_word[5]), 32'h0);

        // Random traffic, thresholds reprogrammed now and then.
        for (int n = 0; n < 4000; n++) begin
            if (n % 97 == 0) begin
                tx_thresh = CW'($urandom_range(DEPTH, 0));
                rx_thresh = CW'($urandom_range(DEPTH, 0));
            end
            cyc(($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0,
                ($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0,
                ($urandom % 5) == 0, ($urandom % 300) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule